// File: doc/BRIEF.md
# Memory Bridge with Explicit Wait

This block sits between a processor's internal data bus and a memory that is slower than a register transfer. It holds two registers: an address register and a buffer register. Each one loads from the internal bus when its load enable is high. The buffer register also drives the bus back when its output enable is high. The controller's microword carries a two-bit memory function: none, read, write or wait. The block turns a read or a write into a request/acknowledge handshake on the memory side.

A memory operation takes two microwords. The first issues the read or write. A later wait microword retires it. When the operation is issued, the address is taken from the address register, and for a write the data is taken from the buffer register. Read data returns into the buffer register. While a wait microword is active and memory has not yet acknowledged, the stall output is high so that the controller holds its sequence.

An operation stays outstanding until a wait has been taken. A read or write that arrives while one is outstanding is dropped, and the block flags a protocol error.

Top module: `mem_bridge`

## Requirements
- R1: After synchronous reset, `mem_req`, `mem_we`, `stall` and `proto_err` are low, both registers hold zero, and `bus_out` is zero.
- R2: Register loads and bus drive:
  - When `mar_ld` is high, the address register takes `bus_in` at the clock edge. When `mbr_ld` is high, the buffer register does the same.
  - `bus_out` equals the buffer register while `mbr_oe` is high and is zero otherwise.
  - A register whose load enable is low keeps its value.
- R3: `mem_func` encodes none as 2'b00, read as 2'b01, write as 2'b10 and wait as 2'b11. When no operation is outstanding, a read or write is accepted. In the next cycle:
  - `mem_req` is high.
  - `mem_addr` holds the address register's value.
  - `mem_we` is high for a write, with `mem_wdata` holding the buffer register's value.
- R4: `mem_req` stays high until the cycle in which `mem_ack` is sampled high, and falls in the following cycle. `mem_addr`, `mem_we` and `mem_wdata` do not change while it is high, even if the address register is reloaded.
- R5: On the edge where a read is acknowledged, the buffer register takes `mem_rdata`. This has priority over a simultaneous `mbr_ld`.
- R6: `stall` is high exactly when the function is wait, a request is pending, and `mem_ack` is low. For a memory latency of L cycles after the request rises, a wait issued right after the request stalls for L-1 cycles. A wait with nothing outstanding does not stall.
- R7: An operation is outstanding from its issue until a wait is taken in or after its acknowledge cycle. A read or write given while an operation is outstanding starts nothing and leaves both registers unchanged. `proto_err` is high for exactly the one following cycle.
- R8: Data written to an address is returned by a later read of that address, at every memory latency from 1 to 5 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | DW | Internal bus value offered to the registers |
| mar_ld | input | 1 | Load the address register from the bus |
| mbr_ld | input | 1 | Load the buffer register from the bus |
| mbr_oe | input | 1 | Drive the buffer register onto the bus |
| bus_out | output | DW | Buffer register value when driven, else zero |
| mem_func | input | 2 | Memory function from the microword |
| stall | output | 1 | Controller must hold the current microword |
| proto_err | output | 1 | A read or write was dropped in the previous cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Memory completion |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |

## Verification
The in-line assertions check, on every cycle, that:
- the request is held until it is acknowledged and dropped after it;
- the request fields stay frozen while the request is pending;
- a stalled wait cycle is always followed by a request that is still pending;
- a read or write arriving during an outstanding operation raises the error flag;
- acknowledged read data lands in the buffer register.

Some behaviour only the bench's scenarios can show:
- the exact stall length at each latency;
- that a dropped command leaves memory contents and registers untouched;
- that reading data back matches earlier writes across a full sweep of addresses and latencies.

// File: rtl/mif_pkg.sv
package mif_pkg;
  typedef enum logic [1:0] {
    MF_NONE  = 2'b00,
    MF_READ  = 2'b01,
    MF_WRITE = 2'b10,
    MF_WAIT  = 2'b11
  } mfunc_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'b00,
    SQ_BUSY = 2'b01,
    SQ_DONE = 2'b10
  } sq_e;
endpackage

// File: rtl/mif_reg.sv
module mif_reg #(
  parameter int W       = 16,
  parameter bit HAS_ALT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_ld,
  input  logic [W-1:0] bus_d,
  input  logic         alt_ld,
  input  logic [W-1:0] alt_d,
  output logic [W-1:0] q
);
  generate
    if (HAS_ALT) begin : g_alt
      always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (alt_ld) q <= alt_d;
        else if (bus_ld) q <= bus_d;
      end
    end else begin : g_plain
      logic unused_alt;
      assign unused_alt = alt_ld ^ (^alt_d);
      always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (bus_ld) q <= bus_d;
      end
    end
  endgenerate
endmodule

// File: rtl/mif_seq.sv
module mif_seq
  import mif_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] func,
  input  logic       mem_ack,
  output logic       issue,
  output logic       issue_we,
  output logic       rd_land,
  output logic       mem_req,
  output logic       mem_we,
  output logic       stall,
  output logic       proto_err
);
  sq_e    state, state_nx;
  mfunc_e f;
  logic   is_rw, reject, is_wait;

  assign f        = mfunc_e'(func);
  assign is_rw    = (f == MF_READ) || (f == MF_WRITE);
  assign is_wait  = (f == MF_WAIT);
  assign issue    = is_rw && (state == SQ_IDLE);
  assign issue_we = (f == MF_WRITE);
  assign reject   = is_rw && (state != SQ_IDLE);
  assign mem_req  = (state == SQ_BUSY);
  assign stall    = is_wait && mem_req && !mem_ack;
  assign rd_land  = mem_req && mem_ack && !mem_we;

  always_comb begin
    state_nx = state;
    case (state)
      SQ_IDLE: if (issue) state_nx = SQ_BUSY;
      SQ_BUSY: if (mem_ack) state_nx = is_wait ? SQ_IDLE : SQ_DONE;
      SQ_DONE: if (is_wait) state_nx = SQ_IDLE;
      default: state_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      mem_we    <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      state     <= state_nx;
      proto_err <= reject;
      if (issue) mem_we <= issue_we;
    end
  end

  // R4: request held until acknowledged, dropped after
  a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req);
  a_r4_req_drop: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack |=> !mem_req);
  // R6: a stalled cycle leaves the request pending
  a_r6_stall_pending: assert property (@(posedge clk) disable iff (rst)
    stall |=> mem_req);
  // R7: command during pending request flags an error
  a_r7_reject_flag: assert property (@(posedge clk) disable iff (rst)
    mem_req && ((func == 2'b01) || (func == 2'b10)) |=> proto_err);
endmodule

// File: rtl/mem_bridge.sv
module mem_bridge #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] bus_in,
  input  logic          mar_ld,
  input  logic          mbr_ld,
  input  logic          mbr_oe,
  output logic [DW-1:0] bus_out,
  input  logic [1:0]    mem_func,
  output logic          stall,
  output logic          proto_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int AW_USE = (AW < DW) ? AW : DW;

  logic [AW-1:0] mar_q;
  logic [DW-1:0] mbr_q;
  logic [AW-1:0] mar_d;
  logic          issue, issue_we, rd_land;

  always_comb begin
    mar_d = '0;
    mar_d[AW_USE-1:0] = bus_in[AW_USE-1:0];
  end

  mif_reg #(.W(AW), .HAS_ALT(1'b0)) u_mar (
    .clk(clk), .rst(rst), .bus_ld(mar_ld), .bus_d(mar_d),
    .alt_ld(1'b0), .alt_d('0), .q(mar_q)
  );

  mif_reg #(.W(DW), .HAS_ALT(1'b1)) u_mbr (
    .clk(clk), .rst(rst), .bus_ld(mbr_ld), .bus_d(bus_in),
    .alt_ld(rd_land), .alt_d(mem_rdata), .q(mbr_q)
  );

  mif_seq u_seq (
    .clk(clk), .rst(rst), .func(mem_func), .mem_ack(mem_ack),
    .issue(issue), .issue_we(issue_we), .rd_land(rd_land),
    .mem_req(mem_req), .mem_we(mem_we), .stall(stall),
    .proto_err(proto_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (issue) begin
      mem_addr  <= mar_q;
      mem_wdata <= mbr_q;
    end
  end

  assign bus_out = mbr_oe ? mbr_q : '0;

  logic unused_we;
  assign unused_we = issue_we;

  // R4: request fields frozen while pending
  a_r4_fields_stable: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we));
  // R5: acknowledged read data lands in the buffer register
  a_r5_read_lands: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack && !mem_we |=> mbr_q == $past(mem_rdata));
  // R3: accepted command raises the request with the captured address
  a_r3_issue_req: assert property (@(posedge clk) disable iff (rst)
    !mem_req && !proto_err && issue |=> mem_req && (mem_addr == $past(mar_q)));
endmodule

// File: tb/mem_bridge_tb.sv
module mem_bridge_tb;
  localparam int AW = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] bus_in = '0;
  logic mar_ld = 1'b0, mbr_ld = 1'b0, mbr_oe = 1'b0;
  logic [1:0] mem_func = 2'b00;
  logic mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] bus_out, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic stall, proto_err, mem_req, mem_we;

  int n_chk = 0, n_bad = 0;
  int lat_sel = 1;
  int cnt = 0;
  logic [DW-1:0] mem [16];

  always #4 clk = ~clk;

  mem_bridge #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .bus_in(bus_in), .mar_ld(mar_ld), .mbr_ld(mbr_ld),
    .mbr_oe(mbr_oe), .bus_out(bus_out), .mem_func(mem_func), .stall(stall),
    .proto_err(proto_err), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  // memory responder, latency counted in cycles after the request rises
  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        cnt = cnt + 1;
        if (cnt == lat_sel) begin
          mem_ack = 1'b1;
          mem_rdata = mem[mem_addr];
          if (mem_we) mem[mem_addr] = mem_wdata;
        end
      end else begin
        mem_ack = 1'b0;
        cnt = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_mar(input int a);
    @(negedge clk); bus_in = DW'(a); mar_ld = 1'b1;
    @(negedge clk); mar_ld = 1'b0;
  endtask

  task automatic load_mbr(input int d);
    @(negedge clk); bus_in = DW'(d); mbr_ld = 1'b1;
    @(negedge clk); mbr_ld = 1'b0;
  endtask

  task automatic peek_mbr(output int v);
    mbr_oe = 1'b1; #1; v = int'(bus_out); mbr_oe = 1'b0; #1;
  endtask

  // issue an operation, then wait it out while counting stall cycles
  task automatic run_op(input bit wr, input int a, input int d, input int lat);
    int stalls;
    lat_sel = lat;
    load_mar(a);
    if (wr) load_mbr(d);
    @(negedge clk); mem_func = wr ? 2'b10 : 2'b01;
    @(negedge clk); mem_func = 2'b11; #2;
    chk(mem_req == 1'b1 && mem_we == wr, "R3", int'(mem_req), 1);
    chk(mem_addr == AW'(a), "R3", int'(mem_addr), a);
    if (wr) chk(mem_wdata == DW'(d), "R3", int'(mem_wdata), d);
    stalls = 0;
    while (stall) begin
      stalls++;
      @(negedge clk); #2;
    end
    chk(stalls == lat - 1, "R6", stalls, lat - 1);
    @(negedge clk); mem_func = 2'b00; #2;
    chk(mem_req == 1'b0, "R4", int'(mem_req), 0);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0; #2;
    // R1 reset state
    chk(!mem_req && !mem_we && !stall && !proto_err, "R1", int'(mem_req), 0);
    peek_mbr(v);
    chk(v == 0, "R1", v, 0);
    chk(mem_addr == '0, "R1", int'(mem_addr), 0);

    // R2 buffer register load, hold and drive
    load_mbr(8'h5C);
    @(negedge clk); bus_in = 8'hFF; #2;
    chk(bus_out == '0, "R2", int'(bus_out), 0);
    peek_mbr(v);
    chk(v == 8'h5C, "R2", v, 8'h5C);

    // R6 wait with nothing outstanding
    @(negedge clk); mem_func = 2'b11; #2;
    chk(stall == 1'b0, "R6", int'(stall), 0);
    @(negedge clk); mem_func = 2'b00; #2;
    chk(!mem_req && !proto_err, "R6", int'(mem_req), 0);

    // R8 sweep: write every address at each latency, then read back
    for (int lat = 1; lat <= 5; lat++) begin
      for (int a = 0; a < 16; a++)
        run_op(1'b1, a, (a * 37 + lat * 11 + 5) & 8'hFF, lat);
      for (int a = 0; a < 16; a++) begin
        run_op(1'b0, a, 0, 6 - lat);
        peek_mbr(v);
        chk(v == ((a * 37 + lat * 11 + 5) & 8'hFF), "R8", v, (a * 37 + lat * 11 + 5) & 8'hFF);
      end
    end

    // R7/R4: command rejected during a pending read, MAR reload ignored
    lat_sel = 5;
    load_mar(3);
    @(negedge clk); mem_func = 2'b01;
    @(negedge clk); mem_func = 2'b10; #2;
    chk(proto_err == 1'b0, "R7", int'(proto_err), 0);
    @(negedge clk); mem_func = 2'b00; bus_in = 8'h09; mar_ld = 1'b1; #2;
    chk(proto_err == 1'b1, "R7", int'(proto_err), 1);
    chk(mem_we == 1'b0, "R7", int'(mem_we), 0);
    @(negedge clk); mar_ld = 1'b0; #2;
    chk(proto_err == 1'b0, "R7", int'(proto_err), 0);
    chk(mem_req && mem_addr == AW'(3), "R4", int'(mem_addr), 3);
    @(negedge clk); mem_func = 2'b11; #2;
    while (stall) begin @(negedge clk); #2; end
    @(negedge clk); mem_func = 2'b00; #2;
    peek_mbr(v);
    chk(v == int'(mem[3]), "R7", v, int'(mem[3]));

    // R7: command rejected after acknowledge but before the wait
    lat_sel = 1;
    load_mar(5);
    @(negedge clk); mem_func = 2'b01;
    @(negedge clk); mem_func = 2'b00;
    @(negedge clk); mem_func = 2'b10;
    @(negedge clk); mem_func = 2'b00; #2;
    chk(proto_err == 1'b1 && mem_req == 1'b0, "R7", int'(proto_err), 1);
    @(negedge clk); mem_func = 2'b11; #2;
    chk(stall == 1'b0, "R6", int'(stall), 0);
    @(negedge clk); mem_func = 2'b00; #2;
    peek_mbr(v);
    chk(v == int'(mem[5]), "R7", v, int'(mem[5]));

    // R5: read data wins over a bus load in the acknowledge cycle
    load_mar(7);
    @(negedge clk); mem_func = 2'b01;
    @(negedge clk); mem_func = 2'b11; bus_in = 8'hAA; mbr_ld = 1'b1; #2;
    chk(stall == 1'b0, "R6", int'(stall), 0);
    @(negedge clk); mem_func = 2'b00; mbr_ld = 1'b0; #2;
    peek_mbr(v);
    chk(v == int'(mem[7]), "R5", v, int'(mem[7]));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule